// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into a stream of column addresses, one per clock, for an SDRAM-style memory array or a behavioural memory model. A request is a start strobe with a start column, a read/write flag and a 10-bit mode word. The mode word supplies three things. The first is a length code, which selects 1, 2, 4 or 8 beats or a full page. The second is the ordering: addresses either count up or are formed by XOR. The third is a write override that cuts writes down to a single beat.

Each beat carries a valid flag. The final beat of a fixed-length burst also carries a last flag. A burst-stop input ends any burst at once. A full-page burst runs until it is stopped. A fresh start strobe restarts the sequence at any time. Data storage, command decoding and read latency belong to the surrounding logic.

Top module: `burst_col_gen`

## Requirements
- R1: When `rst_n` is low at a clock edge, `col_valid` and `col_last` are both 0 in the following cycle, and they stay 0 until a start is sampled.
- R2: A start sampled at a clock edge makes `col_valid` 1 in the next cycle, with `col_out` equal to the sampled `start_col`. After that, one new address is presented per clock. The mode word and `is_write` are sampled together with the start.
- R3: The length code is `mode_cfg[2:0]`: 000 gives 1 beat, 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. The reserved codes 100, 101 and 110 behave as 1 beat. Bits 8..4 of `mode_cfg` have no effect.
- R4: When `mode_cfg[3]` is 0, the order is sequential. The low address bits count up from the start and wrap inside the aligned block of the burst length. The upper bits keep the start value. For example, a 4-beat burst from 0x0A6 gives 0A6, 0A7, 0A4, 0A5.
- R5: When `mode_cfg[3]` is 1, the order is interleaved. The low bits equal the start offset XOR the beat index. For example, an 8-beat burst from 0x105 gives 105, 104, 107, 106, 101, 100, 103, 102.
- R6: Length code 111 selects a full page. The order is sequential over all 512 columns, wrapping from 511 to 0, and `mode_cfg[3]` is ignored. The burst continues until a stop, and `col_last` is never 1 during it.
- R7: `col_last` is 1 exactly on the final beat of a fixed-length burst. Unless a new start is sampled on that edge, `col_valid` is 0 in the next cycle.
- R8: A `stop` sampled while no start is sampled makes `col_valid` 0 in the next cycle, at any burst length.
- R9: When `mode_cfg[9]` is 1, a write (`is_write`=1) is a single beat. A read still uses the programmed length. When `mode_cfg[9]` is 0, writes use the programmed length.
- R10: A start sampled during an active burst restarts the sequence from the new start column on the next clock. A start takes priority over a `stop` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst; samples `start_col`, `mode_cfg` and `is_write` |
| is_write | input | 1 | The burst is a write |
| start_col | input | 9 | First column of the burst |
| mode_cfg | input | 10 | Length code [2:0], order [3], single-beat write [9] |
| stop | input | 1 | End the current burst |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions assume that `start`, `stop` and the sampled inputs are known, 0 or 1, at every clock edge after reset. They also assume that nothing outside the block expects a burst to continue past an edge where `stop` or a new `start` is sampled. The bench drives every input on the falling edge from a single process, so each input holds steady across every rising edge. It raises `stop` only on cycles with no start, except in the one test that checks start priority. Interleaved full-page mode words are also driven, and the checks expect sequential order for them.

// File: rtl/burst_col_pkg.sv
// Shared definitions for the burst column address generator.
// Assumes the mode word layout: length [2:0], order [3], write override [9].
package burst_col_pkg;

    localparam int MODE_W    = 10;
    localparam int LEN_LSB   = 0;
    localparam int ORDER_BIT = 3;
    localparam int WOVR_BIT  = 9;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

endpackage

// File: rtl/burst_mode_dec.sv
// Decodes the mode word and the read/write flag into a wrap mask, an order
// select and a full-page flag.
// Assumes COL_W >= 3. Reserved length codes act as one beat.
module burst_mode_dec
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [MODE_W-1:0] mode_cfg,
    input  logic              is_write,
    output logic [COL_W-1:0]  wrap_mask,
    output logic              use_xor,
    output logic              full_page
);

    localparam logic [COL_W-1:0] MASK_1    = '0;
    localparam logic [COL_W-1:0] MASK_2    = COL_W'(1);
    localparam logic [COL_W-1:0] MASK_4    = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_8    = COL_W'(7);
    localparam logic [COL_W-1:0] MASK_PAGE = '1;

    logic [2:0] len_field;
    logic       single_write;
    logic       unused_mode_bits;

    assign len_field        = mode_cfg[LEN_LSB +: 3];
    assign single_write     = mode_cfg[WOVR_BIT] & is_write;
    assign unused_mode_bits = ^mode_cfg[WOVR_BIT-1:ORDER_BIT+1];

    // Map the length code to a wrap mask; the write override wins.
    always_comb begin
        full_page = 1'b0;
        wrap_mask = MASK_1;
        if (!single_write) begin
            case (len_field)
                LEN_TWO:   wrap_mask = MASK_2;
                LEN_FOUR:  wrap_mask = MASK_4;
                LEN_EIGHT: wrap_mask = MASK_8;
                LEN_PAGE: begin
                    wrap_mask = MASK_PAGE;
                    full_page = 1'b1;
                end
                default:   wrap_mask = MASK_1;
            endcase
        end
    end

    // A full page always runs sequentially.
    always_comb use_xor = mode_cfg[ORDER_BIT] & ~full_page;

endmodule

// File: rtl/burst_beat_ctr.sv
// Holds the burst state: the active flag, the beat index and the latched
// start column and mode. A start has priority over a stop.
// Assumes wrap_in is of the form 2**k-1.
module burst_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] wrap_in,
    input  logic             xor_in,
    input  logic             page_in,
    output logic             active,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] wrap_mask,
    output logic             use_xor,
    output logic             full_page,
    output logic             final_beat
);

    // A fixed-length burst ends when the index reaches the mask.
    always_comb final_beat = active & ~full_page & (beat_idx == wrap_mask);

    // Advance, restart or end the burst once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            beat_idx  <= '0;
            base_col  <= '0;
            wrap_mask <= '0;
            use_xor   <= 1'b0;
            full_page <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            beat_idx  <= '0;
            base_col  <= start_col;
            wrap_mask <= wrap_in;
            use_xor   <= xor_in;
            full_page <= page_in;
        end else if (stop || final_beat) begin
            active    <= 1'b0;
        end else if (active) begin
            beat_idx  <= beat_idx + 1'b1;
        end
    end

endmodule

// File: rtl/burst_addr_map.sv
// Forms the column address of the current beat from the base column, the
// beat index and the wrap mask. Bits above the mask keep the base value.
// Assumes the mask is contiguous from bit 0.
module burst_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             use_xor,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_xor;

    // Compute both orderings inside the block and pick one.
    always_comb begin
        low_seq = (base_col + beat_idx) & wrap_mask;
        low_xor = (base_col ^ beat_idx) & wrap_mask;
        col     = (base_col & ~wrap_mask) | (use_xor ? low_xor : low_seq);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column address generator. It emits one column per clock
// after a start, with valid and last flags.
// Assumes inputs are synchronous to clk; the mode word is sampled with start.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic [MODE_W-1:0] mode_cfg,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_xor;
    logic             dec_page;
    logic             st_active;
    logic [COL_W-1:0] st_idx;
    logic [COL_W-1:0] st_base;
    logic [COL_W-1:0] st_mask;
    logic             st_xor;
    logic             st_page;
    logic             st_final;

    burst_mode_dec #(.COL_W(COL_W)) dec_i (
        .mode_cfg  (mode_cfg),
        .is_write  (is_write),
        .wrap_mask (dec_mask),
        .use_xor   (dec_xor),
        .full_page (dec_page)
    );

    burst_beat_ctr #(.COL_W(COL_W)) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .start_col  (start_col),
        .wrap_in    (dec_mask),
        .xor_in     (dec_xor),
        .page_in    (dec_page),
        .active     (st_active),
        .beat_idx   (st_idx),
        .base_col   (st_base),
        .wrap_mask  (st_mask),
        .use_xor    (st_xor),
        .full_page  (st_page),
        .final_beat (st_final)
    );

    burst_addr_map #(.COL_W(COL_W)) map_i (
        .base_col  (st_base),
        .beat_idx  (st_idx),
        .wrap_mask (st_mask),
        .use_xor   (st_xor),
        .col       (col_out)
    );

    // Drive the beat flags from the burst state.
    always_comb begin
        col_valid = st_active;
        col_last  = st_final;
    end

    logic unused_page;
    assign unused_page = st_page;

endmodule

// File: rtl/burst_col_chk.sv
// Port-level properties of the burst column address generator.
// Assumes start and stop are known at every edge after reset.
module burst_col_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!col_valid && !col_last)); // R1

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col))); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid); // R7

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R7

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !col_valid); // R8

    AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !stop) |=> col_valid); // R6

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

    localparam int COL_W = 9;
    localparam int VW    = 96;
    localparam int NVEC  = 12;

    // Layout: mode[95:86] wr[85] start[84:76] beats[75:72] seq[71:0]
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {10'h002, 1'b0, 9'h0A6, 4'd4, 9'h0A6, 9'h0A7, 9'h0A4, 9'h0A5, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h00B, 1'b0, 9'h105, 4'd8, 9'h105, 9'h104, 9'h107, 9'h106, 9'h101, 9'h100, 9'h103, 9'h102},
        {10'h001, 1'b0, 9'h1FF, 4'd2, 9'h1FF, 9'h1FE, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h000, 1'b0, 9'h033, 4'd1, 9'h033, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h005, 1'b0, 9'h044, 4'd1, 9'h044, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h00E, 1'b0, 9'h045, 4'd1, 9'h045, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h003, 1'b0, 9'h00D, 4'd8, 9'h00D, 9'h00E, 9'h00F, 9'h008, 9'h009, 9'h00A, 9'h00B, 9'h00C},
        {10'h203, 1'b1, 9'h010, 4'd1, 9'h010, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h203, 1'b0, 9'h012, 4'd8, 9'h012, 9'h013, 9'h014, 9'h015, 9'h016, 9'h017, 9'h010, 9'h011},
        {10'h003, 1'b1, 9'h020, 4'd8, 9'h020, 9'h021, 9'h022, 9'h023, 9'h024, 9'h025, 9'h026, 9'h027},
        {10'h00A, 1'b0, 9'h0C3, 4'd4, 9'h0C3, 9'h0C2, 9'h0C1, 9'h0C0, 9'h0, 9'h0, 9'h0, 9'h0},
        {10'h1F2, 1'b0, 9'h001, 4'd4, 9'h001, 9'h002, 9'h003, 9'h000, 9'h0, 9'h0, 9'h0, 9'h0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             is_write = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [9:0]       mode_cfg = '0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_write  (is_write),
        .start_col (start_col),
        .mode_cfg  (mode_cfg),
        .stop      (stop),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Drive a start on the next falling edge; returns at the edge showing beat 0.
    task automatic kick(input logic [9:0] m, input logic wr, input logic [8:0] c);
        @(negedge clk);
        start = 1'b1; mode_cfg = m; is_write = wr; start_col = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid after reset", int'(col_valid), 0);
        check("R1 last after reset", int'(col_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle until start", int'(col_valid), 0);

        // Table walk: R2 R3 R4 R5 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            int nb;
            nb = int'(VEC[v][75:72]);
            kick(VEC[v][95:86], VEC[v][85], VEC[v][84:76]);
            for (int b = 0; b < nb; b++) begin
                check($sformatf("R2/R3/R4/R5/R9 vec%0d beat%0d col", v, b),
                      int'(col_out), int'(VEC[v][71-9*b -: 9]));
                check($sformatf("R2 vec%0d beat%0d valid", v, b), int'(col_valid), 1);
                check($sformatf("R7 vec%0d beat%0d last", v, b), int'(col_last), (b == nb-1) ? 1 : 0);
                @(negedge clk);
            end
            check($sformatf("R7 vec%0d ends", v), int'(col_valid), 0);
        end

        // R6: full page from 0x1FE wraps over 512 columns, no last, then stop (R8)
        kick(10'h007, 1'b0, 9'h1FE);
        for (int b = 0; b < 520; b++) begin
            check("R6 page col", int'(col_out), (9'h1FE + b) % 512);
            check("R6 page valid", int'(col_valid), 1);
            check("R6 page last", int'(col_last), 0);
            if (b == 519) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check("R8 stop ends page", int'(col_valid), 0);

        // R6: interleave bit ignored in full page
        kick(10'h00F, 1'b0, 9'h003);
        for (int b = 0; b < 6; b++) begin
            check("R6 page order sequential", int'(col_out), 3 + b);
            if (b == 5) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check("R8 stop ends page ilv", int'(col_valid), 0);

        // R8: stop in the middle of an 8-beat burst
        kick(10'h003, 1'b0, 9'h040);
        @(negedge clk);
        @(negedge clk);
        check("R8 mid col", int'(col_out), 9'h042);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R8 stop mid burst", int'(col_valid), 0);
        @(negedge clk);
        check("R8 stays idle", int'(col_valid), 0);

        // R10: restart during an active burst
        kick(10'h003, 1'b0, 9'h080);
        @(negedge clk);
        kick(10'h002, 1'b0, 9'h102);
        check("R10 restart col", int'(col_out), 9'h102);
        @(negedge clk);
        check("R10 restart next", int'(col_out), 9'h103);
        @(negedge clk);
        check("R10 restart wrap", int'(col_out), 9'h100);
        @(negedge clk);
        check("R10 restart last", int'(col_last), 1);
        @(negedge clk);

        // R10: start wins over stop on the same edge
        @(negedge clk);
        start = 1'b1; stop = 1'b1; mode_cfg = 10'h001; is_write = 1'b0; start_col = 9'h0F0;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check("R10 start beats stop valid", int'(col_valid), 1);
        check("R10 start beats stop col", int'(col_out), 9'h0F0);
        @(negedge clk);
        check("R10 second beat", int'(col_out), 9'h0F1);

        // R1: reset in the middle of a burst
        kick(10'h003, 1'b0, 9'h000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid burst valid", int'(col_valid), 0);
        check("R1 reset mid burst last", int'(col_last), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule